// File: doc/BRIEF.md
# Break-Before-Make Output Stage Sequencer

This block drives the gate enables of a bank of push-pull output channels, each built from a high-side and a low-side transistor. For every channel it takes one digital data bit, which arrives already sliced by an upstream comparator. It turns the matching transistor on so that the output follows that bit. Whenever the bit changes, the conducting transistor is switched off at once. Both transistors then stay off for a programmable number of clock cycles before the opposite one is switched on. This keeps the two devices of a channel from ever conducting together.

Three plain control levels can force every channel into high impedance: a three-state request, an undervoltage flag and an overtemperature flag. While any of them is active, both enables of every channel are low. When all three are released, each channel goes through one full dead interval and then drives its current data bit, with no further command needed. All inputs pass through one register stage. The reset value of that stage treats the three-state request as active, the same as an undriven mode pin. The data bits are level signals that are sampled every cycle. No valid/ready handshake applies: the output always follows the most recent sample, and back-pressure does not exist at either edge.

Top module: `drv_gate_seq`

## Requirements
- R1: While reset is asserted, and in the first cycles after it, every high-side and low-side enable is low. The input stage resets to the three-state request, so nothing is driven until the request has been sampled low and one dead interval has elapsed.
- R2: In no cycle are the high-side enable and the low-side enable of the same channel high together.
- R3: A change of a channel's data bit takes effect at the second rising clock edge after the change. At that edge the conducting enable falls.
- R4: After the conducting enable falls, both enables of that channel stay low for exactly DEAD_CYC cycles. The enable for the new data value then rises.
- R5: If the data bit changes again while the channel is in its dead interval, the interval starts over from the edge where the change is seen. The next enable rises only after DEAD_CYC cycles with no further change.
- R6: A high level on the three-state request drives all enables low from the second rising edge after it rises. A low level allows push-pull operation.
- R7: A high level on the undervoltage flag or the overtemperature flag drives all enables low with the same two-edge latency as R6.
- R8: When the three-state request and both fault flags are all low again, each channel keeps both enables low for DEAD_CYC cycles. It then enables the transistor that matches its data bit, without any other command.
- R9: In steady state, data bit 1 enables the high-side transistor only, and data bit 0 enables the low-side transistor only.
- R10: The channels are independent. A data change on one channel leaves the enables of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_data_i | input | NCH | Digitised data bit per channel |
| tri_req_i | input | 1 | 1 requests high impedance on all channels, 0 requests push-pull |
| uv_flag_i | input | 1 | Undervoltage fault flag, active high |
| ot_flag_i | input | 1 | Overtemperature fault flag, active high |
| hs_en_o | output | NCH | High-side gate enable per channel |
| ls_en_o | output | NCH | Low-side gate enable per channel |

## Verification
The bench builds the block with NCH = 4 and DEAD_CYC = 5. A dead interval five cycles long lets random data toggles, at a rate of about one in ten cycles per channel, often land inside an interval. This exercises the restart path of R5 as well as clean transitions. A directed sweep places a second toggle at every offset from 1 to DEAD_CYC inside the interval. This covers both the earliest restart and the restart on the last dead cycle. Short random bursts of the three-state request and the fault flags, some of them overlapping, exercise the forced high-impedance state and the recovery of R8 from every channel state.

// File: rtl/drv_gate_pkg.sv
package drv_gate_pkg;

  // Per-channel sequencing state
  typedef enum logic [1:0] {
    CH_HIZ  = 2'd0,  // both transistors off, forced
    CH_DEAD = 2'd1,  // both off, waiting out the gap
    CH_HI   = 2'd2,  // high side conducting
    CH_LO   = 2'd3   // low side conducting
  } ch_state_e;

endpackage

// File: rtl/drv_gate_guard.sv
// Input stage: registers data, mode request and fault flags, and merges
// the high-impedance conditions into a single inhibit level.
module drv_gate_guard #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] data_i,
  input  logic           tri_req_i,
  input  logic           uv_i,
  input  logic           ot_i,
  output logic [NCH-1:0] data_o,
  output logic           inh_o
);

  logic [NCH-1:0] data_q;
  logic           tri_q;
  logic           uv_q;
  logic           ot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      tri_q  <= 1'b1;   // undriven mode pin reads as three-state request
      uv_q   <= 1'b0;
      ot_q   <= 1'b0;
    end else begin
      data_q <= data_i;
      tri_q  <= tri_req_i;
      uv_q   <= uv_i;
      ot_q   <= ot_i;
    end
  end

  assign data_o = data_q;
  assign inh_o  = tri_q | uv_q | ot_q;

  // R6/R7: any request seen at the previous edge inhibits now
  a_r6_request_inhibits : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tri_req_i || uv_i || ot_i)) |-> inh_o);

endmodule

// File: rtl/drv_gate_chan.sv
// One channel: turn conducting side off, wait DEAD_CYC cycles, turn other on.
module drv_gate_chan
  import drv_gate_pkg::*;
#(
  parameter int DEAD_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inh_i,
  input  logic d_i,
  output logic hi_en_o,
  output logic lo_en_o
);

  localparam int CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(DEAD_CYC - 1);

  ch_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_HIZ;
      cnt_q   <= '0;
      tgt_q   <= 1'b0;
    end else if (inh_i) begin
      state_q <= CH_HIZ;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        CH_HIZ: begin
          state_q <= CH_DEAD;
          tgt_q   <= d_i;
          cnt_q   <= CNT_LOAD;
        end
        CH_DEAD: begin
          if (d_i != tgt_q) begin
            tgt_q <= d_i;           // restart the gap
            cnt_q <= CNT_LOAD;
          end else if (cnt_q == '0) begin
            state_q <= tgt_q ? CH_HI : CH_LO;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        CH_HI: begin
          if (!d_i) begin
            state_q <= CH_DEAD;
            tgt_q   <= 1'b0;
            cnt_q   <= CNT_LOAD;
          end
        end
        CH_LO: begin
          if (d_i) begin
            state_q <= CH_DEAD;
            tgt_q   <= 1'b1;
            cnt_q   <= CNT_LOAD;
          end
        end
        default: state_q <= CH_HIZ;
      endcase
    end
  end

  assign hi_en_o = (state_q == CH_HI);
  assign lo_en_o = (state_q == CH_LO);

  // Checker counter: cycles with both enables low, saturating at DEAD_CYC
  logic [CW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_q <= '0;
    else if (hi_en_o || lo_en_o)    gap_q <= '0;
    else if (gap_q != CW'(DEAD_CYC)) gap_q <= gap_q + CW'(1);
  end

  a_r2_no_overlap : assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_en_o && lo_en_o));

  a_r4_full_gap : assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi_en_o) || $rose(lo_en_o)) |-> (gap_q == CW'(DEAD_CYC)));

  a_r6_inhibit_off : assert property (@(posedge clk) disable iff (!rst_n)
    inh_i |=> (!hi_en_o && !lo_en_o));

  a_r9_hi_polarity : assert property (@(posedge clk) disable iff (!rst_n)
    hi_en_o |-> $past(d_i));

  a_r9_lo_polarity : assert property (@(posedge clk) disable iff (!rst_n)
    lo_en_o |-> !$past(d_i));

endmodule

// File: rtl/drv_gate_seq.sv
module drv_gate_seq #(
  parameter int NCH      = 4,
  parameter int DEAD_CYC = 20   // 200 ns at a 100 MHz clock
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_data_i,
  input  logic           tri_req_i,
  input  logic           uv_flag_i,
  input  logic           ot_flag_i,
  output logic [NCH-1:0] hs_en_o,
  output logic [NCH-1:0] ls_en_o
);

  logic [NCH-1:0] data_s;
  logic           inh_s;

  drv_gate_guard #(.NCH(NCH)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_i    (chan_data_i),
    .tri_req_i (tri_req_i),
    .uv_i      (uv_flag_i),
    .ot_i      (ot_flag_i),
    .data_o    (data_s),
    .inh_o     (inh_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    drv_gate_chan #(.DEAD_CYC(DEAD_CYC)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .inh_i   (inh_s),
      .d_i     (data_s[c]),
      .hi_en_o (hs_en_o[c]),
      .lo_en_o (ls_en_o[c])
    );
  end

  // R7: a fault seen two edges back leaves every enable low
  a_r7_fault_hiz : assert property (@(posedge clk) disable iff (!rst_n)
    $past(uv_flag_i || ot_flag_i, 2) |-> (hs_en_o == '0 && ls_en_o == '0));

endmodule

// File: tb/drv_gate_seq_bench.sv
module drv_gate_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int DEAD       = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] chan_data = '0;
  logic           tri_req = 1'b1;
  logic           uv = 1'b0;
  logic           ot = 1'b0;
  logic [NCH-1:0] hs_en, ls_en;

  int checks = 0;
  int bad    = 0;
  bit in_reset = 1'b1;

  // model state
  logic [NCH-1:0] stg_d = '0;
  logic           stg_inh = 1'b1;
  logic           stg_tri = 1'b1;
  int             run [NCH];
  bit             from_hiz [NCH];
  bit             restarted [NCH];
  logic           lastd [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  drv_gate_seq #(.NCH(NCH), .DEAD_CYC(DEAD)) u_drv_gate_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_data_i (chan_data),
    .tri_req_i   (tri_req),
    .uv_flag_i   (uv),
    .ot_flag_i   (ot),
    .hs_en_o     (hs_en),
    .ls_en_o     (ls_en)
  );

  function automatic string pick_tag(bit inh, bit by_mode, int r, bit fh, bit rs);
    if (inh)            return by_mode ? "R6" : "R7";
    if (r <= DEAD)      return rs ? "R5" : (r == 1 ? "R3" : "R4");
    if (r == DEAD + 1)  return fh ? "R8" : (rs ? "R5" : "R4");
    return "R9";
  endfunction

  task automatic check(string tag, int ch, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s ch%0d: hi/lo=%b expected %b", tag, ch, act, exp);
    end
  endtask

  // Advance one clock, update the model for that edge, check outputs.
  task automatic step();
    logic [NCH-1:0] fd;
    bit finh, fmode;
    @(negedge clk);
    if (in_reset) begin
      stg_d = '0; stg_inh = 1'b1; stg_tri = 1'b1;
      for (int c = 0; c < NCH; c++) begin
        run[c] = 0; from_hiz[c] = 0; restarted[c] = 0; lastd[c] = 1'b0;
        check("R1", c, {hs_en[c], ls_en[c]}, 2'b00);
      end
      return;
    end
    fd = stg_d; finh = stg_inh; fmode = stg_tri;
    stg_d = chan_data; stg_inh = tri_req | uv | ot; stg_tri = tri_req;
    for (int c = 0; c < NCH; c++) begin
      logic [1:0] exp;
      if (finh) begin
        run[c] = 0; restarted[c] = 0;
      end else if (run[c] == 0) begin
        run[c] = 1; from_hiz[c] = 1; restarted[c] = 0;
      end else if (fd[c] != lastd[c]) begin
        restarted[c] = (run[c] <= DEAD);
        if (!restarted[c]) from_hiz[c] = 0;
        run[c] = 1;
      end else if (run[c] <= DEAD) begin
        run[c]++;
      end else begin
        from_hiz[c] = 0; restarted[c] = 0;
        run[c] = DEAD + 2;
      end
      lastd[c] = fd[c];
      exp = (run[c] >= DEAD + 1) ? {fd[c], ~fd[c]} : 2'b00;
      check(pick_tag(finh, fmode, run[c], from_hiz[c], restarted[c]), c,
            {hs_en[c], ls_en[c]}, exp);
      checks++;
      if (hs_en[c] && ls_en[c]) begin
        bad++;
        $display("FAIL R2 ch%0d: hi/lo=11 expected not 11", c);
      end
    end
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    logic [NCH-1:0] snap_h, snap_l;
    void'($urandom(32'h5EED));
    // R1: reset holds everything off
    steps(4);
    rst_n = 1'b1; in_reset = 1'b0;
    tri_req = 1'b0; chan_data = 4'b1010;
    steps(DEAD + 6);                 // R8: leave HiZ after one gap

    // R10: toggle channel 0 only, others must not move
    snap_h = hs_en; snap_l = ls_en;
    chan_data[0] = ~chan_data[0];
    for (int i = 0; i < DEAD + 3; i++) begin
      step();
      checks++;
      if ((hs_en[NCH-1:1] !== snap_h[NCH-1:1]) || (ls_en[NCH-1:1] !== snap_l[NCH-1:1])) begin
        bad++;
        $display("FAIL R10 others: hi=%b lo=%b expected hi=%b lo=%b",
                 hs_en[NCH-1:1], ls_en[NCH-1:1], snap_h[NCH-1:1], snap_l[NCH-1:1]);
      end
    end

    // R5: second toggle at every offset inside the gap
    for (int k = 1; k <= DEAD + 1; k++) begin
      chan_data[1] = ~chan_data[1];
      steps(k);
      chan_data[1] = ~chan_data[1];
      steps(DEAD + 4);
    end

    // R6 then R7: forced HiZ and recovery
    tri_req = 1'b1; steps(4); tri_req = 1'b0; steps(DEAD + 4);
    uv = 1'b1; steps(3); uv = 1'b0; steps(DEAD + 4);
    ot = 1'b1; chan_data = ~chan_data; steps(3); ot = 1'b0; steps(DEAD + 4);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      for (int c = 0; c < NCH; c++)
        if ($urandom % 10 == 0) chan_data[c] = ~chan_data[c];
      if (!tri_req) tri_req = ($urandom % 200 == 0); else tri_req = !($urandom % 8 == 0);
      if (!uv) uv = ($urandom % 300 == 0); else uv = !($urandom % 6 == 0);
      if (!ot) ot = ($urandom % 300 == 0); else ot = !($urandom % 6 == 0);
      step();
    end
    tri_req = 1'b0; uv = 1'b0; ot = 1'b0;
    steps(DEAD + 4);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule